// File: doc/BRIEF.md
# Serial Flash Deep Power-Down Controller

This block holds the power-state logic on the slave side of a serial memory. It watches SPI mode-0 traffic (active-low select, serial clock, data in) and oversamples it with the system clock. It assembles 8-bit instruction codes MSB first on rising serial-clock edges and keeps the memory in one of three modes:

- Standby: the device is not selected.
- Active: a frame is being received.
- Deep Power-down: the low-power mode.

An internal program, erase or write engine reports a busy level to the block. The block drives a low-power indication and a one-cycle pulse each time it refuses a complete instruction.

The low-power mode has one way in and one way out, and each takes a timed delay counted in system clocks:

- Entry: the power-down instruction must be framed exactly. Select rises right after its eighth bit.
- Exit: only the release instruction leaves the mode. The release instruction can also shift out an 8-bit signature on the data-out line. An identification read returns the same signature, but only while powered up.

Top module: `flashpd_top`

## Requirements
- R1: After reset, dpMode, miso and instrRejected are all 0 and the block is in Standby.
- R2: Opcode 0xB9 framed by exactly 8 rising serial-clock edges with busy low makes dpMode rise. This happens no earlier than ENTER_DLY and no later than ENTER_DLY+8 system clocks after csN rises.
- R3: Select toggling alone, opcode 0xB9 with any other number of clock edges (7, 9, 16), and any other opcode never set dpMode.
- R4: Opcode 0xB9 correctly framed while busy is high at the csN rise leaves dpMode at 0 and produces exactly one instrRejected pulse.
- R5: In Deep Power-down, every complete opcode other than 0xAB (write, program, erase or identification codes) produces one instrRejected pulse and leaves dpMode at 1.
- R6: Opcode 0xAB received in Deep Power-down, followed by a csN rise after at least 8 edges, keeps dpMode at 1 during EXIT_DLY system clocks and then clears it.
- R7: After opcode 0xAB and 24 dummy bits, the next 8 serial clocks carry SIG on miso MSB first, changing on falling edges. This works both in Standby and in Deep Power-down. miso is 0 outside such a read.
- R8: Opcode 0x9F returns SIG on miso during the 8 clocks right after the opcode when not powered down. In Deep Power-down it is rejected and miso stays 0.
- R9: A complete opcode that arrives during the entry or exit delay is ignored and pulses instrRejected. A release sent during the entry delay does not stop the entry, and a power-down sent during the exit delay does not re-enter the low-power mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data in, MSB first |
| busy | input | 1 | Internal program/erase/write cycle running |
| miso | output | 1 | Serial data out (signature) |
| dpMode | output | 1 | Low-power indication |
| instrRejected | output | 1 | One-cycle pulse when an instruction is refused |

## Verification
The bench builds the block with ENTER_DLY=120, EXIT_DLY=150 and SIG=0x10. Both delays are longer than one complete 8-bit frame (about 76 system clocks at the bench's serial rate). A full instruction can therefore be sent and finished inside the entry or exit window, which is what the R9 checks need. Both delays are still short enough that the table-driven sweep of framings and opcodes completes each power cycle quickly. The non-zero signature makes an MSB-first ordering error visible on miso.

// File: rtl/flashpd_pkg.sv
package flashpd_pkg;

  localparam logic [7:0] OP_ENTER_DP = 8'hB9;
  localparam logic [7:0] OP_RELEASE  = 8'hAB;
  localparam logic [7:0] OP_READ_ID  = 8'h9F;

  localparam logic [5:0] RES_LEAD = 6'd32;
  localparam logic [5:0] ID_LEAD  = 6'd8;

  typedef enum logic [2:0] {
    ST_STBY, ST_ACTIVE, ST_ENTER, ST_DEEP, ST_EXIT
  } pwrState_t;

  typedef struct packed {
    logic loadEnter;
    logic loadExit;
    logic armRes;
    logic armId;
  } ctlStrobe_t;

endpackage

// File: rtl/flashpd_datapath.sv
module flashpd_datapath
  import flashpd_pkg::*;
#(
  parameter int ENTER_DLY = 750,
  parameter int EXIT_DLY  = 7500,
  parameter logic [7:0] SIG = 8'h10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sck,
  input  logic       mosi,
  input  ctlStrobe_t strobe,
  output logic       csRise,
  output logic       csFall,
  output logic       opcodeDone,
  output logic [7:0] opcodeNow,
  output logic [7:0] opcode,
  output logic [5:0] bitCnt,
  output logic       dlyDone,
  output logic       miso
);

  localparam int DMAX = (ENTER_DLY > EXIT_DLY) ? ENTER_DLY : EXIT_DLY;
  localparam int CW   = $clog2(DMAX + 1) < 1 ? 1 : $clog2(DMAX + 1);

  logic csQ, csPrev, sckQ, sckPrev, mosiQ;
  logic sckRise, sckFall;
  logic [CW-1:0] dlyCnt;
  logic sigArmed, sigActive;
  logic [5:0] sigLead;
  logic [2:0] outIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csQ <= 1'b1; csPrev <= 1'b1;
      sckQ <= 1'b0; sckPrev <= 1'b0; mosiQ <= 1'b0;
    end else begin
      csQ <= csN; csPrev <= csQ;
      sckQ <= sck; sckPrev <= sckQ; mosiQ <= mosi;
    end
  end

  assign csRise     = csQ & ~csPrev;
  assign csFall     = ~csQ & csPrev;
  assign sckRise    = sckQ & ~sckPrev & ~csQ;
  assign sckFall    = ~sckQ & sckPrev & ~csQ;
  assign opcodeDone = sckRise && (bitCnt == 6'd7);
  assign opcodeNow  = {opcode[6:0], mosiQ};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      opcode <= '0;
    end else if (csQ) begin
      bitCnt <= '0;
    end else if (sckRise) begin
      if (bitCnt != 6'h3F) bitCnt <= bitCnt + 6'd1;
      if (bitCnt < 6'd8) opcode <= opcodeNow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  dlyCnt <= '0;
    else if (strobe.loadEnter)  dlyCnt <= CW'(ENTER_DLY);
    else if (strobe.loadExit)   dlyCnt <= CW'(EXIT_DLY);
    else if (dlyCnt != '0)      dlyCnt <= dlyCnt - 1'b1;
  end
  assign dlyDone = (dlyCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sigArmed <= 1'b0; sigActive <= 1'b0;
      sigLead <= '0; outIdx <= '0;
    end else if (csQ) begin
      sigArmed <= 1'b0; sigActive <= 1'b0;
    end else begin
      if (strobe.armRes) begin sigArmed <= 1'b1; sigLead <= RES_LEAD; end
      if (strobe.armId)  begin sigArmed <= 1'b1; sigLead <= ID_LEAD;  end
      if (sckFall) begin
        if (sigActive) begin
          if (outIdx == 3'd7) sigActive <= 1'b0;
          else                outIdx <= outIdx + 3'd1;
        end else if (sigArmed && bitCnt == sigLead) begin
          sigActive <= 1'b1;
          outIdx    <= 3'd0;
        end
      end
    end
  end

  assign miso = sigActive ? SIG[3'd7 - outIdx] : 1'b0;

  AST_BITCNT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    csQ |=> (bitCnt == 6'd0)); // R3
  AST_MISO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (csQ && $past(csQ)) |-> !miso); // R7

endmodule

// File: rtl/flashpd_control.sv
module flashpd_control
  import flashpd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busy,
  input  logic       csRise,
  input  logic       csFall,
  input  logic       opcodeDone,
  input  logic [7:0] opcodeNow,
  input  logic [7:0] opcode,
  input  logic [5:0] bitCnt,
  input  logic       dlyDone,
  output ctlStrobe_t strobe,
  output logic       dpMode,
  output logic       instrRejected
);

  pwrState_t state, nextState;
  logic deepFrame, nextDeepFrame, rejNext;

  always_comb begin
    nextState     = state;
    nextDeepFrame = deepFrame;
    rejNext       = 1'b0;
    strobe        = '0;
    case (state)
      ST_STBY: begin
        if (csFall) nextState = ST_ACTIVE;
        if (opcodeDone) rejNext = 1'b1;
      end
      ST_ACTIVE: begin
        if (opcodeDone) begin
          if (opcodeNow == OP_RELEASE)      strobe.armRes = 1'b1;
          else if (opcodeNow == OP_READ_ID) strobe.armId  = 1'b1;
        end
        if (csRise) begin
          nextState = ST_STBY;
          if (bitCnt == 6'd8 && opcode == OP_ENTER_DP) begin
            if (busy) rejNext = 1'b1;
            else begin
              strobe.loadEnter = 1'b1;
              nextState        = ST_ENTER;
            end
          end
        end
      end
      ST_ENTER: begin
        if (opcodeDone) rejNext = 1'b1;
        if (dlyDone) nextState = ST_DEEP;
      end
      ST_DEEP: begin
        if (csFall) nextDeepFrame = 1'b1;
        if (opcodeDone) begin
          if (deepFrame && opcodeNow == OP_RELEASE) strobe.armRes = 1'b1;
          else rejNext = 1'b1;
        end
        if (csRise) begin
          nextDeepFrame = 1'b0;
          if (deepFrame && bitCnt >= 6'd8 && opcode == OP_RELEASE) begin
            strobe.loadExit = 1'b1;
            nextState       = ST_EXIT;
          end
        end
      end
      ST_EXIT: begin
        if (opcodeDone) rejNext = 1'b1;
        if (dlyDone) nextState = ST_STBY;
      end
      default: nextState = ST_STBY;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state         <= ST_STBY;
      deepFrame     <= 1'b0;
      instrRejected <= 1'b0;
    end else begin
      state         <= nextState;
      deepFrame     <= nextDeepFrame;
      instrRejected <= rejNext;
    end
  end

  assign dpMode = (state == ST_DEEP) || (state == ST_EXIT);

  AST_DEEP_ONLY_FROM_ENTER: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DEEP && $past(state) != ST_DEEP) |-> $past(state) == ST_ENTER); // R2
  AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACTIVE && csRise && busy) |=> state != ST_ENTER); // R4
  AST_EXIT_ONLY_FROM_DEEP: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_EXIT && $past(state) != ST_EXIT) |-> $past(state) == ST_DEEP); // R6
  AST_REJECT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    instrRejected |=> !instrRejected); // R5

endmodule

// File: rtl/flashpd_top.sv
module flashpd_top
  import flashpd_pkg::*;
#(
  parameter int ENTER_DLY = 750,
  parameter int EXIT_DLY  = 7500,
  parameter logic [7:0] SIG = 8'h10
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sck,
  input  logic mosi,
  input  logic busy,
  output logic miso,
  output logic dpMode,
  output logic instrRejected
);

  ctlStrobe_t strobe;
  logic csRise, csFall, opcodeDone, dlyDone;
  logic [7:0] opcodeNow, opcode;
  logic [5:0] bitCnt;

  flashpd_datapath #(.ENTER_DLY(ENTER_DLY), .EXIT_DLY(EXIT_DLY), .SIG(SIG)) uData (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .mosi(mosi),
    .strobe(strobe), .csRise(csRise), .csFall(csFall),
    .opcodeDone(opcodeDone), .opcodeNow(opcodeNow), .opcode(opcode),
    .bitCnt(bitCnt), .dlyDone(dlyDone), .miso(miso)
  );

  flashpd_control uCtl (
    .clk(clk), .rstN(rstN), .busy(busy), .csRise(csRise), .csFall(csFall),
    .opcodeDone(opcodeDone), .opcodeNow(opcodeNow), .opcode(opcode),
    .bitCnt(bitCnt), .dlyDone(dlyDone), .strobe(strobe),
    .dpMode(dpMode), .instrRejected(instrRejected)
  );

endmodule

// File: tb/sim_flashpd_top.sv
`timescale 1ns/1ps
module sim_flashpd_top;

  localparam int ENT = 120;
  localparam int EXT = 150;
  localparam logic [7:0] SIGV = 8'h10;

  typedef struct packed {
    logic [7:0] op;
    logic [4:0] nb;
    logic       bsy;
    logic       expDp;
    logic       expRej;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{8'hB9, 5'd8,  1'b0, 1'b1, 1'b0},
    '{8'hB9, 5'd7,  1'b0, 1'b0, 1'b0},
    '{8'hB9, 5'd9,  1'b0, 1'b0, 1'b0},
    '{8'hB9, 5'd16, 1'b0, 1'b0, 1'b0},
    '{8'hB9, 5'd8,  1'b1, 1'b0, 1'b1},
    '{8'h06, 5'd8,  1'b0, 1'b0, 1'b0},
    '{8'hAB, 5'd8,  1'b0, 1'b0, 1'b0},
    '{8'hB8, 5'd8,  1'b0, 1'b0, 1'b0},
    '{8'h00, 5'd0,  1'b0, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sck = 1'b0, mosi = 1'b0, busy = 1'b0;
  logic miso, dpMode, instrRejected;
  int tests = 0, fails = 0, rejCnt = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  flashpd_top #(.ENTER_DLY(ENT), .EXIT_DLY(EXT), .SIG(SIGV)) u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .mosi(mosi), .busy(busy),
    .miso(miso), .dpMode(dpMode), .instrRejected(instrRejected)
  );

  always @(negedge clk) if (instrRejected === 1'b1) rejCnt++;

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic beginFrame();
    csN = 1'b0; waitClk(4);
  endtask

  task automatic endFrame();
    sck = 1'b0; waitClk(4); csN = 1'b1; waitClk(4);
  endtask

  task automatic sendBits(input logic [7:0] op, input int n);
    for (int i = 0; i < n; i++) begin
      sck = 1'b0; mosi = (i < 8) ? op[7-i] : 1'b0; waitClk(4);
      sck = 1'b1; waitClk(4);
    end
  endtask

  task automatic readSig(output logic [7:0] v);
    v = '0;
    for (int i = 0; i < 8; i++) begin
      sck = 1'b0; waitClk(4); v = {v[6:0], miso};
      sck = 1'b1; waitClk(4);
    end
  endtask

  task automatic frame(input logic [7:0] op);
    beginFrame(); sendBits(op, 8); endFrame();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] sig;
    int r0;
    waitClk(5);
    // R1 reset state
    check("R1 dpMode", dpMode, 0);
    check("R1 miso", miso, 0);
    check("R1 instrRejected", instrRejected, 0);
    rstN = 1'b1; waitClk(4);
    check("R1 dpMode after release", dpMode, 0);

    // R3 R4 R2 table of framings
    foreach (VEC[i]) begin
      busy = VEC[i].bsy; r0 = rejCnt;
      beginFrame(); sendBits(VEC[i].op, int'(VEC[i].nb)); endFrame();
      busy = 1'b0; waitClk(ENT + 10);
      check($sformatf("R3/R4 vec%0d dpMode", i), dpMode, VEC[i].expDp);
      check($sformatf("R4 vec%0d reject", i), rejCnt - r0, VEC[i].expRej);
      if (dpMode) begin frame(8'hAB); waitClk(EXT + 10); end
    end

    // R2 exact window
    beginFrame(); sendBits(8'hB9, 8); sck = 1'b0; waitClk(4); csN = 1'b1;
    waitClk(ENT);
    check("R2 not yet low-power", dpMode, 0);
    waitClk(8);
    check("R2 low-power entered", dpMode, 1);

    // R5 R8 ignored instructions in deep power-down
    r0 = rejCnt;
    frame(8'h06); frame(8'h02); frame(8'hD8); frame(8'hC7);
    beginFrame(); sendBits(8'h9F, 8); readSig(sig); endFrame();
    check("R8 no signature in deep", sig, 0);
    check("R5 rejects in deep", rejCnt - r0, 5);
    check("R5 still low-power", dpMode, 1);

    // R6 R7 release with signature
    beginFrame(); sendBits(8'hAB, 8); sendBits(8'h00, 24); readSig(sig);
    sck = 1'b0; waitClk(4); csN = 1'b1;
    check("R7 signature in deep", sig, SIGV);
    waitClk(EXT - 4);
    check("R6 held during exit delay", dpMode, 1);
    waitClk(12);
    check("R6 exit complete", dpMode, 0);
    check("R7 miso idle", miso, 0);

    // R7 standby signature, R8 id read
    beginFrame(); sendBits(8'hAB, 8); sendBits(8'h00, 24); readSig(sig); endFrame();
    check("R7 signature in standby", sig, SIGV);
    waitClk(EXT + 10);
    check("R7 standby unchanged", dpMode, 0);
    beginFrame(); sendBits(8'h9F, 8); readSig(sig); endFrame();
    check("R8 id signature", sig, SIGV);

    // R9 release during entry delay, power-down during exit delay
    frame(8'hB9);
    r0 = rejCnt;
    frame(8'hAB);
    check("R9 release ignored in entry", rejCnt - r0, 1);
    waitClk(ENT + 10);
    check("R9 entry completes", dpMode, 1);
    frame(8'hAB);
    r0 = rejCnt;
    frame(8'hB9);
    check("R9 power-down ignored in exit", rejCnt - r0, 1);
    waitClk(EXT + 10);
    check("R9 exit completes", dpMode, 0);
    waitClk(ENT + 10);
    check("R9 no re-entry", dpMode, 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule